// File: doc/BRIEF.md
# Prescaled Real-Time Timer

This block is a low-speed timekeeper. A reloadable 16-bit prescaler divides the slow clock. Each time the prescaler wraps, a 32-bit free-running counter advances by one. A mode bit can instead make an external once-per-second tick advance the counter directly. The counter value feeds three things: an alarm comparator, a power-of-two modulo detector that raises a sticky status flag, and a second power-of-two modulo detector that emits a one-cycle trigger pulse for other logic.

Software reaches the block through five word registers on a simple synchronous bus: mode, alarm, counter value, status and modulo selection. Status flags are sticky and clear when the status register is read. The interrupt line combines the alarm and increment flags under their enables. The whole block runs in the slow clock domain.

Top module: `prescaled_rt_timer`

## Requirements
- R1: Registers sit at byte offsets 0x00 mode, 0x04 alarm, 0x08 counter value, 0x0C status and 0x10 modulo selection. Reads of unused bits and unmapped offsets return 0. The restart bit (mode bit 18) always reads 0. Writes to 0x08 and 0x0C have no effect.
- R2: With a reload value R in mode[15:0] (R from 1 to 65535), the counter increments once every R cycles, counted from a restart. Each increment sets status bit 1.
- R3: A reload value of 0 divides by 65536.
- R4: A write with mode bit 18 set clears the prescaler and the counter at the clock edge that takes the write.
- R5: While mode bit 20 is set, the prescaler and counter hold, and no status flag or trigger pulse is produced.
- R6: Status bit 0 is set on the increment that makes the counter equal to the alarm register.
- R7: Modulo code k = modsel[2:0] sets status bit 2 on an increment whose new counter value is a multiple of 2^(k+5) (64 up to 4096). Code 0 never sets it. With reload 32 and code 5 the flag rises 32768 cycles after a restart and not before.
- R8: Trigger code k = modsel[10:8] drives trig_evt high for one cycle after an increment whose new value is a multiple of 2^k (2 up to 128). Code 0 produces no pulse.
- R9: Mode bit 21 makes a modulo-flag hit also set status bit 0. Mode bit 22 makes a trigger hit also set status bit 0.
- R10: Mode bit 24 bypasses the prescaler: the counter advances once per cycle in which tick_1hz is high, and does not advance otherwise.
- R11: A status read clears all flags at the edge that takes the read. A flag set at that same edge is kept.
- R12: irq is high when (status bit 0 and mode bit 16) or (status bit 1 and mode bit 17).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | Once-per-second tick, one cycle wide, used when mode bit 24 is set |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| trig_evt | output | 1 | One-cycle trigger pulse |

## Verification
A prescaler that slips a phase shows up at the value register as an off-by-one count within one reload period. For this reason the bench reads the counter at the exact cycles on either side of each increment. A wrong modulo mask or alarm compare shows up as a status bit that is early, late or missing. The bench reads status in the cycle just before and the cycle of the qualifying increment, so a one-edge error is caught. A faulty clear-on-read or a hold that leaks while disabled appears at the next status read or counter read. A trigger pulse that is misplaced or too long is caught by watching trig_evt every cycle.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int REG_ADDR_W = 5;

    localparam logic [REG_ADDR_W-1:0] OFF_MODE   = 5'h00;
    localparam logic [REG_ADDR_W-1:0] OFF_ALARM  = 5'h04;
    localparam logic [REG_ADDR_W-1:0] OFF_VALUE  = 5'h08;
    localparam logic [REG_ADDR_W-1:0] OFF_STATUS = 5'h0C;
    localparam logic [REG_ADDR_W-1:0] OFF_MODSEL = 5'h10;

    localparam int B_ALM_IE   = 16;
    localparam int B_INC_IE   = 17;
    localparam int B_RESTART  = 18;
    localparam int B_DISABLE  = 20;
    localparam int B_MOD_ALM  = 21;
    localparam int B_EVT_ALM  = 22;
    localparam int B_TICK_SEL = 24;

    localparam int SEL_W      = 3;
    localparam int FLAG_SEL_LO = 0;
    localparam int EVT_SEL_LO  = 8;

    typedef struct packed {
        logic modf;
        logic inc;
        logic alm;
    } flags_t;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] reload,
    output logic         roll
);
    logic [W-1:0] presc_d, presc_q;
    logic         at_top;

    always_comb begin
        at_top  = (presc_q == reload - 1'b1);
        roll    = run && !restart && at_top;
        presc_d = presc_q;
        if (restart)
            presc_d = '0;
        else if (run)
            presc_d = at_top ? '0 : presc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_d;
    end

    // R2: after a wrap the prescaler restarts from zero
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> (presc_q == '0));

    // R5: a stopped prescaler keeps its phase
    p_presc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(presc_q));
endmodule

// File: rtl/tt_moddet.sv
module tt_moddet #(
    parameter int VAL_W = 32,
    parameter int SHIFT = 0
) (
    input  logic [2:0]       code,
    input  logic [VAL_W-1:0] value,
    output logic             hit
);
    logic [VAL_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < VAL_W; i++)
            mask[i] = (i < (int'(code) + SHIFT));
        hit = (code != 3'd0) && ((value & mask) == '0);
    end
endmodule

// File: rtl/prescaled_rt_timer.sv
module prescaled_rt_timer
    import tt_pkg::*;
#(
    parameter int PRESC_W    = 16,
    parameter int CNT_W      = 32,
    parameter int DATA_W     = 32,
    parameter int FLAG_SHIFT = 5,
    parameter int EVT_SHIFT  = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_1hz,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq,
    output logic                  trig_evt
);
    localparam int NDET = 2;

    typedef struct packed {
        logic               tick_sel;
        logic               evt_alm;
        logic               mod_alm;
        logic               dis;
        logic               inc_ie;
        logic               alm_ie;
        logic [PRESC_W-1:0] reload;
        logic [SEL_W-1:0]   flag_sel;
        logic [SEL_W-1:0]   evt_sel;
        logic [CNT_W-1:0]   alarm;
        logic [CNT_W-1:0]   cnt;
        flags_t             flags;
        logic               trig;
    } state_t;

    state_t st_d, st_q;

    logic             wr_mode, wr_alarm, wr_modsel, rd_status, restart;
    logic             run_presc, roll, step;
    logic [CNT_W-1:0] cnt_next;
    flags_t           set_now;
    logic [NDET-1:0]  det_hit;
    logic [SEL_W-1:0] det_code [NDET];

    assign det_code[0] = st_q.flag_sel;
    assign det_code[1] = st_q.evt_sel;

    always_comb begin
        wr_mode   = bus_sel && bus_wr  && (bus_addr == OFF_MODE);
        wr_alarm  = bus_sel && bus_wr  && (bus_addr == OFF_ALARM);
        wr_modsel = bus_sel && bus_wr  && (bus_addr == OFF_MODSEL);
        rd_status = bus_sel && !bus_wr && (bus_addr == OFF_STATUS);
        restart   = wr_mode && bus_wdata[B_RESTART];
        run_presc = !st_q.dis && !st_q.tick_sel;
    end

    tt_prescaler #(.W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_presc),
        .restart (restart),
        .reload  (st_q.reload),
        .roll    (roll)
    );

    always_comb begin
        step     = !st_q.dis && !restart && (st_q.tick_sel ? tick_1hz : roll);
        cnt_next = st_q.cnt + 1'b1;
    end

    for (genvar g = 0; g < NDET; g++) begin : g_det
        tt_moddet #(
            .VAL_W (CNT_W),
            .SHIFT ((g == 0) ? FLAG_SHIFT : EVT_SHIFT)
        ) u_det (
            .code  (det_code[g]),
            .value (cnt_next),
            .hit   (det_hit[g])
        );
    end

    always_comb begin
        set_now.inc  = step;
        set_now.modf = step && det_hit[0];
        set_now.alm  = step && ((cnt_next == st_q.alarm)
                             || (st_q.mod_alm && det_hit[0])
                             || (st_q.evt_alm && det_hit[1]));

        st_d = st_q;
        if (wr_mode) begin
            st_d.reload   = bus_wdata[PRESC_W-1:0];
            st_d.alm_ie   = bus_wdata[B_ALM_IE];
            st_d.inc_ie   = bus_wdata[B_INC_IE];
            st_d.dis      = bus_wdata[B_DISABLE];
            st_d.mod_alm  = bus_wdata[B_MOD_ALM];
            st_d.evt_alm  = bus_wdata[B_EVT_ALM];
            st_d.tick_sel = bus_wdata[B_TICK_SEL];
        end
        if (wr_alarm)
            st_d.alarm = bus_wdata[CNT_W-1:0];
        if (wr_modsel) begin
            st_d.flag_sel = bus_wdata[FLAG_SEL_LO +: SEL_W];
            st_d.evt_sel  = bus_wdata[EVT_SEL_LO +: SEL_W];
        end

        if (restart)   st_d.cnt = '0;
        else if (step) st_d.cnt = cnt_next;

        st_d.flags = (rd_status ? flags_t'('0) : st_q.flags) | set_now;
        st_d.trig  = step && det_hit[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_MODE: begin
                bus_rdata[PRESC_W-1:0] = st_q.reload;
                bus_rdata[B_ALM_IE]    = st_q.alm_ie;
                bus_rdata[B_INC_IE]    = st_q.inc_ie;
                bus_rdata[B_DISABLE]   = st_q.dis;
                bus_rdata[B_MOD_ALM]   = st_q.mod_alm;
                bus_rdata[B_EVT_ALM]   = st_q.evt_alm;
                bus_rdata[B_TICK_SEL]  = st_q.tick_sel;
            end
            OFF_ALARM:  bus_rdata[CNT_W-1:0] = st_q.alarm;
            OFF_VALUE:  bus_rdata[CNT_W-1:0] = st_q.cnt;
            OFF_STATUS: bus_rdata[$bits(flags_t)-1:0] = st_q.flags;
            OFF_MODSEL: begin
                bus_rdata[FLAG_SEL_LO +: SEL_W] = st_q.flag_sel;
                bus_rdata[EVT_SEL_LO +: SEL_W]  = st_q.evt_sel;
            end
            default: bus_rdata = '0;
        endcase
        irq      = (st_q.flags.alm && st_q.alm_ie) || (st_q.flags.inc && st_q.inc_ie);
        trig_evt = st_q.trig;
    end

    // R2: the counter moves only by one step or back to zero
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != $past(st_q.cnt)) |-> ((st_q.cnt == $past(st_q.cnt) + CNT_W'(1)) || (st_q.cnt == '0)));

    // R2: a fresh increment flag comes with a counter step
    p_inc_flag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flags.inc) |-> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // R5: disabled and not restarted keeps the counter
    p_hold_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dis && !restart) |=> $stable(st_q.cnt));

    // R6: with extra alarm sources off, a new alarm means a compare match
    p_alarm_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.flags.alm) && !$past(st_q.mod_alm) && !$past(st_q.evt_alm))
        |-> (st_q.cnt == $past(st_q.alarm)));

    // R8: the trigger pulse lasts one cycle
    p_trig_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_evt |=> !trig_evt);
endmodule

// File: tb/prescaled_rt_timer_bench.sv
`timescale 1ns/1ps
module prescaled_rt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, trig_evt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prescaled_rt_timer u_prescaled_rt_timer (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .trig_evt(trig_evt)
    );

    localparam logic [4:0] A_MODE = 5'h00, A_ALARM = 5'h04, A_VALUE = 5'h08,
                           A_STAT = 5'h0C, A_MSEL = 5'h10;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic quiesce();
        logic [31:0] d;
        wr(A_MODE, 32'h0014_0000);
        rd(A_STAT, d);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_VALUE, d); chk("R1 reset count", d, 0);
        rd(A_STAT, d);  chk("R1 reset status", d, 0);
        rd(A_MODE, d);  chk("R1 reset mode", d, 0);
        chk("R12 reset irq", {31'b0, irq}, 0);
        chk("R8 reset trig", {31'b0, trig_evt}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(A_MODE, 32'hFFFF_FFFF);
        rd(A_MODE, d);  chk("R1 mode readback, restart bit 0", d, 32'h0173_FFFF);
        wr(A_ALARM, 32'hDEAD_BEEF);
        rd(A_ALARM, d); chk("R1 alarm readback", d, 32'hDEAD_BEEF);
        wr(A_MSEL, 32'hFFFF_FFFF);
        rd(A_MSEL, d);  chk("R1 modsel readback", d, 32'h0000_0707);
        wr(A_VALUE, 32'h1234);
        rd(A_VALUE, d); chk("R1 value write ignored", d, 0);
        rd(A_STAT, d);
        wr(A_STAT, 32'h7);
        rd(A_STAT, d);  chk("R1 status write ignored", d, 0);
        rd(5'h14, d);   chk("R1 unmapped reads 0", d, 0);
        wr(A_MSEL, 0);
    endtask

    task automatic t_prescale();
        logic [31:0] d;
        quiesce();
        wr(A_MODE, 32'h0004_0004);
        repeat (11) @(negedge clk);
        rd(A_VALUE, d); chk("R2 count before 3rd step", d, 2);
        rd(A_VALUE, d); chk("R2 count at 3rd step", d, 3);
        rd(A_STAT, d);  chk("R2 increment flag", d, 32'h2);
        rd(A_STAT, d);  chk("R11 cleared by read", d, 0);
    endtask

    task automatic t_reload0();
        logic [31:0] d;
        quiesce();
        wr(A_MODE, 32'h0004_0000);
        repeat (65535) @(negedge clk);
        rd(A_VALUE, d); chk("R3 no step before 65536", d, 0);
        rd(A_VALUE, d); chk("R3 step at 65536", d, 1);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        quiesce();
        wr(A_MODE, 32'h0004_0002);
        repeat (7) @(negedge clk);
        rd(A_VALUE, d); chk("R4 count before restart", d, 3);
        wr(A_MODE, 32'h0004_0002);
        rd(A_VALUE, d); chk("R4 restart clears count", d, 0);
    endtask

    task automatic t_disable();
        logic [31:0] d, c0;
        int pulses = 0;
        quiesce();
        wr(A_MSEL, 32'h0000_0100);
        wr(A_MODE, 32'h0004_0002);
        repeat (6) @(negedge clk);
        wr(A_MODE, 32'h0010_0002);
        rd(A_STAT, d);
        rd(A_VALUE, c0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (trig_evt) pulses++;
        end
        rd(A_VALUE, d); chk("R5 count held", d, c0);
        rd(A_STAT, d);  chk("R5 no flags", d, 0);
        chk("R5 no trigger", pulses, 0);
        wr(A_MSEL, 0);
    endtask

    task automatic t_alarm_irq();
        logic [31:0] d;
        quiesce();
        wr(A_ALARM, 5);
        wr(A_MODE, 32'h0005_0001);
        repeat (4) @(negedge clk);
        rd(A_STAT, d);  chk("R6 no alarm before match", d & 1, 0);
        chk("R12 irq on alarm", {31'b0, irq}, 1);
        rd(A_STAT, d);  chk("R6 alarm at match, R11 kept", d & 1, 1);
        chk("R12 irq low after clear", {31'b0, irq}, 0);
        wr(A_MODE, 32'h0002_0001);
        chk("R12 irq from increment", {31'b0, irq}, 1);
    endtask

    task automatic t_modflag();
        logic [31:0] d;
        quiesce();
        wr(A_MSEL, 1);
        wr(A_MODE, 32'h0004_0001);
        repeat (63) @(negedge clk);
        rd(A_STAT, d);  chk("R7 code1 none at 63", d & 4, 0);
        rd(A_STAT, d);  chk("R7 code1 flag at 64", d & 4, 4);
        quiesce();
        wr(A_MSEL, 0);
        wr(A_MODE, 32'h0004_0001);
        repeat (130) @(negedge clk);
        rd(A_STAT, d);  chk("R7 code0 never", d & 4, 0);
        quiesce();
        wr(A_MSEL, 5);
        wr(A_MODE, 32'h0004_0020);
        repeat (32767) @(negedge clk);
        rd(A_STAT, d);  chk("R7 one second: none early", d & 4, 0);
        rd(A_STAT, d);  chk("R7 one second: flag", d & 4, 4);
    endtask

    task automatic t_trigger();
        int bad = 0, pulses = 0;
        quiesce();
        wr(A_MSEL, 32'h0000_0300);
        wr(A_MODE, 32'h0004_0001);
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (trig_evt) pulses++;
            if (trig_evt !== ((i % 8) == 0)) bad++;
        end
        chk("R8 pulse placement mod 8", bad, 0);
        chk("R8 pulse count mod 8", pulses, 5);
        wr(A_MSEL, 0);
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (trig_evt) pulses++;
        end
        chk("R8 code0 no pulse", pulses, 0);
    endtask

    task automatic t_alarm_src();
        logic [31:0] d;
        quiesce();
        wr(A_ALARM, 32'hFFFF_FFFF);
        wr(A_MSEL, 1);
        wr(A_MODE, 32'h0024_0001);
        repeat (63) @(negedge clk);
        rd(A_STAT, d);  chk("R9 modulo source quiet", d & 1, 0);
        rd(A_STAT, d);  chk("R9 modulo source alarm", d, 7);
        quiesce();
        wr(A_MSEL, 32'h0000_0200);
        wr(A_MODE, 32'h0044_0001);
        repeat (3) @(negedge clk);
        rd(A_STAT, d);  chk("R9 trigger source quiet", d & 1, 0);
        rd(A_STAT, d);  chk("R9 trigger source alarm", d & 1, 1);
        wr(A_MSEL, 0);
    endtask

    task automatic t_tick();
        logic [31:0] d;
        quiesce();
        wr(A_MODE, 32'h0104_0004);
        repeat (20) @(negedge clk);
        rd(A_VALUE, d); chk("R10 no tick no step", d, 0);
        for (int i = 0; i < 3; i++) begin
            tick_1hz = 1'b1;
            @(negedge clk);
            tick_1hz = 1'b0;
            repeat (2) @(negedge clk);
        end
        rd(A_VALUE, d); chk("R10 three ticks", d, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_prescale();
        t_reload0();
        t_restart();
        t_disable();
        t_alarm_irq();
        t_modflag();
        t_trigger();
        t_alarm_src();
        t_tick();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule